// File: doc/BRIEF.md
# Partitioned Nonvolatile Memory Decoder

This block sits between a processor's memory access stage and a battery-backed static RAM. Each cycle it takes a 16-bit logical address with a program-or-data type and steers the access to one of three places: the primary RAM bank, a second bank that holds data only, or the external expanded bus. Its outputs are registered, so every result appears one clock after the request that caused it.

The primary bank holds both code and data. A runtime-programmable boundary value splits it. Addresses below the boundary are code, and data writes to them are refused. Addresses at or above the boundary are data and can be written. The physical address driven to the RAM has its two top bits inverted relative to the logical address. When the supply is not valid, every enable and the write strobe go inactive.

A build-time option selects a small-RAM configuration. In that configuration only the low 13 address bits are decoded and the primary bank ends at 1FFFh.

Top module: `nvmem_decoder`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, ce1_n, ce2_n and rw_n are 1, exp_sel is 0 and phys_addr is 0.
- R2: A requested access with bank2_sel=0 (or any program access) whose address is below the primary limit (8000h by default) gives ce1_n=0, ce2_n=1, exp_sel=0 one cycle later.
- R3: A requested access whose address is at or above the primary limit gives exp_sel=1 with ce1_n=1 and ce2_n=1, except for a data access with bank2_sel=1, which never asserts exp_sel.
- R4: A requested data access with bank2_sel=1 gives ce2_n=0, ce1_n=1, exp_sel=0 for any address. At most one of ce1_n=0, ce2_n=0 and exp_sel=1 holds in any cycle.
- R5: bank2_sel has no effect on program accesses. They are decoded as in R2/R3 and ce2_n stays 1.
- R6: A data write to the primary bank gives rw_n=0 when the address is at or above part_bound. It gives rw_n=1 (with ce1_n still 0) when the address is below it.
- R7: part_bound=8000h protects the whole primary bank from writes. part_bound=0000h protects none of it.
- R8: Data writes to bank 2 give rw_n=0. Writes routed to the expanded bus, and program accesses with wr_req=1, give rw_n=1.
- R9: phys_addr equals the logical address bits 14:0 with bits 14 and 13 inverted, one cycle later.
- R10: When pwr_ok=0, the next cycle has ce1_n=1, ce2_n=1, rw_n=1 and exp_sel=0.
- R11: With mem_req=0, the next cycle has both enables and rw_n at 1 and exp_sel at 0.
- R12: With SMALL_RAM=1 the primary limit is 2000h: address 1FFFh selects ce1_n=0 and address 2000h selects exp_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Access request this cycle |
| is_prog | input | 1 | 1 = program fetch, 0 = data access |
| wr_req | input | 1 | Write request |
| bank2_sel | input | 1 | Steer data accesses to the second bank |
| part_bound | input | 16 | Code/data boundary inside the primary bank |
| pwr_ok | input | 1 | Supply valid |
| addr | input | 16 | Logical address |
| ce1_n | output | 1 | Primary bank enable, active low |
| ce2_n | output | 1 | Second bank enable, active low |
| rw_n | output | 1 | Write strobe, 0 = write permitted |
| exp_sel | output | 1 | Route to the expanded bus |
| phys_addr | output | 15 | Physical RAM address, top two bits inverted |

## Verification
The hardest case is the edge of the write-protection boundary, where rw_n must differ between two adjacent addresses while ce1_n stays asserted. The stimulus writes exactly at part_bound and one byte below it, and also drives the extreme boundary values 0000h and 8000h. A second bench instance built with the small-RAM option exercises the 1FFFh/2000h edge, which is unreachable in the default build.

// File: rtl/nvdec_pkg.sv
package nvdec_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_BANK1 = 2'd1,
    TGT_BANK2 = 2'd2,
    TGT_EXP   = 2'd3
  } tgt_e;
endpackage

// File: rtl/nvdec_route.sv
module nvdec_route
  import nvdec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PRIM_LIMIT = 32768
) (
  input  logic              mem_req,
  input  logic              is_prog,
  input  logic              bank2_sel,
  input  logic              pwr_ok,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);
  localparam int LIM_W = ADDR_W + 1;
  localparam logic [LIM_W-1:0] LIMIT = LIM_W'(PRIM_LIMIT);

  logic in_prim;
  assign in_prim = {1'b0, addr} < LIMIT;

  always_comb begin
    if (!mem_req || !pwr_ok)        tgt = TGT_NONE;
    else if (!is_prog && bank2_sel) tgt = TGT_BANK2;
    else if (in_prim)               tgt = TGT_BANK1;
    else                            tgt = TGT_EXP;
  end
endmodule

// File: rtl/nvdec_guard.sv
module nvdec_guard
  import nvdec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  tgt_e              tgt,
  input  logic              is_prog,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] part_bound,
  output logic              wr_ok
);
  logic in_code;
  assign in_code = addr < part_bound;

  always_comb begin
    wr_ok = 1'b0;
    if (wr_req && !is_prog) begin
      case (tgt)
        TGT_BANK2: wr_ok = 1'b1;
        TGT_BANK1: wr_ok = !in_code;
        default:   wr_ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/nvdec_phys.sv
module nvdec_phys #(
  parameter int              PHYS_W   = 15,
  parameter logic [PHYS_W-1:0] INV_MASK = 15'h6000
) (
  input  logic [PHYS_W-1:0] la,
  output logic [PHYS_W-1:0] pa
);
  for (genvar i = 0; i < PHYS_W; i++) begin : g_bit
    if (INV_MASK[i]) begin : g_inv
      assign pa[i] = ~la[i];
    end else begin : g_pass
      assign pa[i] = la[i];
    end
  end
endmodule

// File: rtl/nvmem_decoder.sv
module nvmem_decoder
  import nvdec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PHYS_W    = 15,
  parameter bit SMALL_RAM = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_req,
  input  logic              is_prog,
  input  logic              wr_req,
  input  logic              bank2_sel,
  input  logic [ADDR_W-1:0] part_bound,
  input  logic              pwr_ok,
  input  logic [ADDR_W-1:0] addr,
  output logic              ce1_n,
  output logic              ce2_n,
  output logic              rw_n,
  output logic              exp_sel,
  output logic [PHYS_W-1:0] phys_addr
);
  localparam int SMALL_BITS = 13;
  localparam int PRIM_LIMIT = SMALL_RAM ? (1 << SMALL_BITS) : (1 << PHYS_W);
  localparam logic [PHYS_W-1:0] INV_MASK = PHYS_W'(3) << (PHYS_W - 2);

  tgt_e              tgt;
  logic              wr_ok;
  logic [PHYS_W-1:0] pa_c;

  nvdec_route #(.ADDR_W(ADDR_W), .PRIM_LIMIT(PRIM_LIMIT)) u_route (
    .mem_req(mem_req), .is_prog(is_prog), .bank2_sel(bank2_sel),
    .pwr_ok(pwr_ok), .addr(addr), .tgt(tgt)
  );

  nvdec_guard #(.ADDR_W(ADDR_W)) u_guard (
    .tgt(tgt), .is_prog(is_prog), .wr_req(wr_req), .addr(addr),
    .part_bound(part_bound), .wr_ok(wr_ok)
  );

  nvdec_phys #(.PHYS_W(PHYS_W), .INV_MASK(INV_MASK)) u_phys (
    .la(addr[PHYS_W-1:0]), .pa(pa_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ce1_n     <= 1'b1;
      ce2_n     <= 1'b1;
      rw_n      <= 1'b1;
      exp_sel   <= 1'b0;
      phys_addr <= '0;
    end else begin
      ce1_n     <= (tgt != TGT_BANK1);
      ce2_n     <= (tgt != TGT_BANK2);
      exp_sel   <= (tgt == TGT_EXP);
      rw_n      <= !wr_ok;
      phys_addr <= pa_c;
    end
  end
endmodule

// File: rtl/nvdec_chk.sv
module nvdec_chk #(
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              is_prog,
  input logic              wr_req,
  input logic              bank2_sel,
  input logic [ADDR_W-1:0] part_bound,
  input logic              pwr_ok,
  input logic [ADDR_W-1:0] addr,
  input logic              ce1_n,
  input logic              ce2_n,
  input logic              rw_n,
  input logic              exp_sel,
  input logic [PHYS_W-1:0] phys_addr
);
  // R10
  pwr_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> (ce1_n && ce2_n && rw_n && !exp_sel));

  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({!ce1_n, !ce2_n, exp_sel}) <= 1);

  // R6
  code_wp_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && pwr_ok && !is_prog && wr_req && !bank2_sel && (addr < part_bound)) |=> rw_n);

  // R5
  prog_no_b2_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && is_prog) |=> ce2_n);

  // R3
  b2_no_exp_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !is_prog && bank2_sel) |=> !exp_sel);

  // R9
  phys_map_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> (phys_addr[PHYS_W-3:0] == $past(addr[PHYS_W-3:0])) &&
                (phys_addr[PHYS_W-1:PHYS_W-2] == ~$past(addr[PHYS_W-1:PHYS_W-2])));
endmodule

bind nvmem_decoder nvdec_chk #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .is_prog(is_prog), .wr_req(wr_req),
  .bank2_sel(bank2_sel), .part_bound(part_bound), .pwr_ok(pwr_ok), .addr(addr),
  .ce1_n(ce1_n), .ce2_n(ce2_n), .rw_n(rw_n), .exp_sel(exp_sel), .phys_addr(phys_addr)
);

// File: tb/sim_nvmem_decoder.sv
module sim_nvmem_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req = 1'b0, is_prog = 1'b0, wr_req = 1'b0, bank2_sel = 1'b0, pwr_ok = 1'b1;
  logic [15:0] part_bound = 16'h4000, addr = 16'h0000;
  logic        ce1_n, ce2_n, rw_n, exp_sel;
  logic [14:0] phys_addr;
  logic        s_ce1_n, s_ce2_n, s_rw_n, s_exp_sel;
  logic [14:0] s_phys;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  nvmem_decoder u0 (
    .clk(clk), .rst(rst), .mem_req(mem_req), .is_prog(is_prog), .wr_req(wr_req),
    .bank2_sel(bank2_sel), .part_bound(part_bound), .pwr_ok(pwr_ok), .addr(addr),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .rw_n(rw_n), .exp_sel(exp_sel), .phys_addr(phys_addr)
  );

  nvmem_decoder #(.SMALL_RAM(1'b1)) u1 (
    .clk(clk), .rst(rst), .mem_req(mem_req), .is_prog(is_prog), .wr_req(wr_req),
    .bank2_sel(bank2_sel), .part_bound(part_bound), .pwr_ok(pwr_ok), .addr(addr),
    .ce1_n(s_ce1_n), .ce2_n(s_ce2_n), .rw_n(s_rw_n), .exp_sel(s_exp_sel), .phys_addr(s_phys)
  );

  // {tag, req prog wr b2 pwr, addr, bound, expected ce1_n ce2_n rw_n exp_sel}
  localparam int NV = 18;
  localparam logic [44:0] VEC [NV] = '{
    {4'd2,  5'b10001, 16'h0100, 16'h4000, 4'b0110},  // R2 data read low
    {4'd2,  5'b11001, 16'h7FFF, 16'h4000, 4'b0110},  // R2 fetch at top of bank
    {4'd3,  5'b10001, 16'h8000, 16'h4000, 4'b1111},  // R3 data above limit
    {4'd3,  5'b11001, 16'hC000, 16'h4000, 4'b1111},  // R3 fetch above limit
    {4'd4,  5'b10011, 16'h0123, 16'h4000, 4'b1010},  // R4 bank2 low
    {4'd4,  5'b10011, 16'h9000, 16'h4000, 4'b1010},  // R4 bank2 high, no expanded
    {4'd5,  5'b11011, 16'h0200, 16'h4000, 4'b0110},  // R5 fetch ignores bank2
    {4'd5,  5'b11011, 16'hA000, 16'h4000, 4'b1111},  // R5 fetch ignores bank2 high
    {4'd6,  5'b10101, 16'h5000, 16'h4000, 4'b0100},  // R6 write in data part
    {4'd6,  5'b10101, 16'h3FFF, 16'h4000, 4'b0110},  // R6 write just below bound
    {4'd6,  5'b10101, 16'h4000, 16'h4000, 4'b0100},  // R6 write at bound
    {4'd7,  5'b10101, 16'h7FFF, 16'h8000, 4'b0110},  // R7 whole bank code
    {4'd7,  5'b10101, 16'h0000, 16'h0000, 4'b0100},  // R7 whole bank data
    {4'd8,  5'b10111, 16'h1000, 16'h8000, 4'b1000},  // R8 bank2 write
    {4'd8,  5'b10101, 16'h9000, 16'h0000, 4'b1111},  // R8 expanded write
    {4'd8,  5'b11101, 16'h6000, 16'h0000, 4'b0110},  // R8 program write refused
    {4'd10, 5'b10100, 16'h5000, 16'h0000, 4'b1110},  // R10 power invalid
    {4'd11, 5'b00101, 16'h5000, 16'h0000, 4'b1110}   // R11 no request
  };

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", {ce1_n, ce2_n, rw_n, exp_sel, phys_addr}, {4'b1110, 15'h0000});
    mem_req = 1'b1; addr = 16'h0100;
    @(negedge clk);
    rst = 1'b0; mem_req = 1'b0;
    // R1: first cycle after release still shows reset values
    check("R1", {ce1_n, ce2_n, rw_n, exp_sel, phys_addr}, {4'b1110, 15'h0000});

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      {mem_req, is_prog, wr_req, bank2_sel, pwr_ok} = v[40:36];
      addr = v[35:20];
      part_bound = v[19:4];
      @(negedge clk);
      check($sformatf("R%0d vec%0d", v[44:41], i),
            {ce1_n, ce2_n, rw_n, exp_sel, 15'h0}, {v[3:0], 15'h0});
      // R9 physical address scramble
      check($sformatf("R9 vec%0d", i), {4'h0, phys_addr},
            {4'h0, ~v[34], ~v[33], v[32:20]});
    end

    // R12 small RAM configuration edge
    pwr_ok = 1'b1; mem_req = 1'b1; is_prog = 1'b0; wr_req = 1'b0; bank2_sel = 1'b0;
    addr = 16'h1FFF;
    @(negedge clk);
    check("R12 1FFF", {s_ce1_n, s_ce2_n, s_rw_n, s_exp_sel, 15'h0}, {4'b0110, 15'h0});
    addr = 16'h2000;
    @(negedge clk);
    check("R12 2000", {s_ce1_n, s_ce2_n, s_rw_n, s_exp_sel, 15'h0}, {4'b1111, 15'h0});
    // R2 same address still in primary bank for full build
    check("R2 2000 full", {ce1_n, ce2_n, rw_n, exp_sel, 15'h0}, {4'b0110, 15'h0});

    // R10 power drop in the middle of a write stream, then recovery
    wr_req = 1'b1; addr = 16'h6000; part_bound = 16'h4000; pwr_ok = 1'b0;
    @(negedge clk);
    check("R10 drop", {ce1_n, ce2_n, rw_n, exp_sel, 15'h0}, {4'b1110, 15'h0});
    pwr_ok = 1'b1;
    @(negedge clk);
    check("R6 recover", {ce1_n, ce2_n, rw_n, exp_sel, 15'h0}, {4'b0100, 15'h0});

    // R1 reset asserted mid-stream
    rst = 1'b1;
    @(negedge clk);
    check("R1 re-reset", {ce1_n, ce2_n, rw_n, exp_sel, phys_addr}, {4'b1110, 15'h0000});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule